// File: doc/BRIEF.md
# Two-Channel DMA Transfer Counter

This block keeps the remaining-transfer count for each of two DMA channels. Software loads a channel's 10-bit count over a small register bus, either as one 16-bit word or as separate low and high bytes. The channel's DMA engine raises a busy flag for the duration of a run and pulses a done strobe once per completed transfer. Each strobe taken while busy lowers the count by one. A stored zero loaded before a run stands for 1024 transfers: the first decrement wraps it to 3FFH and the count then runs down to zero. Software can read the count at any time, including mid-run, to see how many transfers remain. Writes are locked out for a channel while that channel is running.

Each channel has a small state machine with two states. CH_IDLE is the resting state, and writes are accepted in it. CH_RUN follows the engine's busy flag. The START transition goes from CH_IDLE to CH_RUN when busy is high. The STOP transition goes from CH_RUN back to CH_IDLE when busy falls. A write is accepted only when the channel is in CH_IDLE and busy is low in that cycle. A one-cycle terminal pulse marks the transfer that brought the count from 1 to 0.

Top module: `dma_xfer_count`

## Requirements
- R1: After reset, both channel counts read 0000H and no terminal pulse is asserted.
- R2: A 16-bit write (bus_size16=1) to address 2n loads channel n bits 9:0 from bus_wdata[9:0]. Write data in bits 15:10 is discarded. A word read always returns bits 15:10 as zero.
- R3: A byte write (bus_size16=0) to address 2n updates only channel n bits 7:0, from bus_wdata[7:0].
- R4: A byte write to address 2n+1 updates only channel n bits 9:8, from bus_wdata[1:0].
- R5: A write to a channel whose busy flag is high, or whose state machine is in CH_RUN, leaves its count unchanged.
- R6: Each done pulse while the channel's busy flag is high lowers its count by one. A done pulse while busy is low is ignored. When a write and a done pulse for an idle channel arrive in the same cycle, the write wins.
- R7: A decrement from 000H gives 3FFH, so a run loaded with zero performs 1024 transfers.
- R8: term_pulse[n] is high for exactly the one cycle after the clock edge at which a decrement takes channel n from 001H to 000H. In that cycle the count reads 000H.
- R9: Reads are combinational and valid during a run. A word read at address 2n returns the count. A byte read at 2n returns bits 7:0 in bus_rdata[7:0], and a byte read at 2n+1 returns bits 9:8 in bus_rdata[1:0]. All other bits of a byte read are zero.
- R10: Activity on one channel never changes the other channel's count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the current bus access |
| bus_addr | input | 2 | Byte address: 2n is channel n low byte, 2n+1 is channel n high byte |
| bus_size16 | input | 1 | 1 = 16-bit word access, 0 = byte access |
| bus_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| bus_rdata | output | 16 | Read data for the addressed register |
| xfer_busy | input | 2 | Per-channel run flag from the DMA engine |
| xfer_done | input | 2 | Per-channel one-cycle transfer-complete strobe |
| term_pulse | output | 2 | Per-channel pulse marking the final transfer of a run |

## Verification
The assertions assume that the engine pulses done at most once per cycle and only when it means a completed transfer. They also assume that busy changes only between clock edges, so the state machine sees it one cycle later. The stimulus drives every input at the falling clock edge and holds it through the following rising edge. It raises done only in single-cycle pulses. Word accesses always use even addresses, because the decoder treats address bit 0 as don't-care for 16-bit accesses.

// File: rtl/dxc_pkg.sv
package dxc_pkg;
    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    localparam int BUS_W  = 16;
    localparam int BYTE_W = 8;
endpackage

// File: rtl/dxc_bus_decode.sv
module dxc_bus_decode
    import dxc_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int CNT_W = 10
) (
    input  logic                    bus_wr,
    input  logic [$clog2(2*NCH)-1:0] bus_addr,
    input  logic                    bus_size16,
    input  logic [BUS_W-1:0]        bus_wdata,
    output logic [NCH-1:0]          wr_lo,
    output logic [NCH-1:0]          wr_hi,
    output logic [BYTE_W-1:0]       lo_data,
    output logic [CNT_W-BYTE_W-1:0] hi_data
);
    localparam int ADDR_W = $clog2(2*NCH);
    localparam int CH_W   = ADDR_W - 1;
    localparam int HI_W   = CNT_W - BYTE_W;

    logic [CH_W-1:0] sel_ch;
    logic            sel_hi;

    assign sel_ch = bus_addr[ADDR_W-1:1];
    assign sel_hi = bus_addr[0];

    always_comb begin
        lo_data = bus_wdata[BYTE_W-1:0];
        if (bus_size16) begin
            hi_data = bus_wdata[CNT_W-1:BYTE_W];
        end else begin
            hi_data = bus_wdata[HI_W-1:0];
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        logic hit;
        assign hit      = bus_wr && (sel_ch == CH_W'(i));
        assign wr_lo[i] = hit && (bus_size16 || !sel_hi);
        assign wr_hi[i] = hit && (bus_size16 || sel_hi);
    end
endmodule

// File: rtl/dxc_chan.sv
module dxc_chan
    import dxc_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_lo_i,
    input  logic                    wr_hi_i,
    input  logic [BYTE_W-1:0]       lo_data_i,
    input  logic [CNT_W-BYTE_W-1:0] hi_data_i,
    input  logic                    busy_i,
    input  logic                    done_i,
    output logic [CNT_W-1:0]        cnt_o,
    output logic                    term_o
);
    localparam int HI_W = CNT_W - BYTE_W;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ch_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             term_q;
    logic             wr_ok, dec_en;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (busy_i)  state_d = CH_RUN;
            CH_RUN:  if (!busy_i) state_d = CH_IDLE;
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        wr_ok  = (state_q == CH_IDLE) && !busy_i;
        dec_en = busy_i && done_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            term_q <= 1'b0;
        end else begin
            term_q <= dec_en && (cnt_q == ONE);
            if (wr_ok && (wr_lo_i || wr_hi_i)) begin
                if (wr_lo_i) cnt_q[BYTE_W-1:0]      <= lo_data_i;
                if (wr_hi_i) cnt_q[CNT_W-1:BYTE_W] <= hi_data_i;
            end else if (dec_en) begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign term_o = term_q;

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !done_i) |=> $stable(cnt_q)); // R5
    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && done_i) |=> (cnt_q == CNT_W'($past(cnt_q) - ONE))); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q)); // R6
    AST_WRAP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && done_i && cnt_q == '0) |=> (cnt_q == '1)); // R7
    AST_TERM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        term_q |-> (cnt_q == '0)); // R8
    AST_TERM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        term_q |=> !term_q); // R8
endmodule

// File: rtl/dxc_read_mux.sv
module dxc_read_mux
    import dxc_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int CNT_W = 10
) (
    input  logic [NCH*CNT_W-1:0]     cnt_flat,
    input  logic [$clog2(2*NCH)-1:0] bus_addr,
    input  logic                     bus_size16,
    output logic [BUS_W-1:0]         bus_rdata
);
    localparam int ADDR_W = $clog2(2*NCH);
    localparam int CH_W   = ADDR_W - 1;
    localparam int HI_W   = CNT_W - BYTE_W;

    logic [CNT_W-1:0] sel_cnt;

    always_comb begin
        sel_cnt = '0;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr[ADDR_W-1:1] == CH_W'(i)) sel_cnt = cnt_flat[i*CNT_W +: CNT_W];
        end
        if (bus_size16) begin
            bus_rdata = {{(BUS_W-CNT_W){1'b0}}, sel_cnt};
        end else if (bus_addr[0]) begin
            bus_rdata = {{(BUS_W-HI_W){1'b0}}, sel_cnt[CNT_W-1:BYTE_W]};
        end else begin
            bus_rdata = {{(BUS_W-BYTE_W){1'b0}}, sel_cnt[BYTE_W-1:0]};
        end
    end
endmodule

// File: rtl/dma_xfer_count.sv
module dma_xfer_count
    import dxc_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int CNT_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [$clog2(2*NCH)-1:0] bus_addr,
    input  logic                     bus_size16,
    input  logic [15:0]              bus_wdata,
    output logic [15:0]              bus_rdata,
    input  logic [NCH-1:0]           xfer_busy,
    input  logic [NCH-1:0]           xfer_done,
    output logic [NCH-1:0]           term_pulse
);
    localparam int HI_W = CNT_W - BYTE_W;

    logic [NCH-1:0]       wr_lo, wr_hi;
    logic [BYTE_W-1:0]    lo_data;
    logic [HI_W-1:0]      hi_data;
    logic [NCH*CNT_W-1:0] cnt_flat;

    dxc_bus_decode #(.NCH(NCH), .CNT_W(CNT_W)) u_dec (
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_size16(bus_size16),
        .bus_wdata (bus_wdata),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .lo_data   (lo_data),
        .hi_data   (hi_data)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dxc_chan #(.CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo_i  (wr_lo[i]),
            .wr_hi_i  (wr_hi[i]),
            .lo_data_i(lo_data),
            .hi_data_i(hi_data),
            .busy_i   (xfer_busy[i]),
            .done_i   (xfer_done[i]),
            .cnt_o    (cnt_flat[i*CNT_W +: CNT_W]),
            .term_o   (term_pulse[i])
        );
    end

    dxc_read_mux #(.NCH(NCH), .CNT_W(CNT_W)) u_rd (
        .cnt_flat  (cnt_flat),
        .bus_addr  (bus_addr),
        .bus_size16(bus_size16),
        .bus_rdata (bus_rdata)
    );

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_size16 |-> (bus_rdata[15:CNT_W] == '0)); // R2
    AST_TERM_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (term_pulse == '0)); // R1
endmodule

// File: tb/dma_xfer_count_tb.sv
module dma_xfer_count_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_size16 = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  xfer_busy = '0;
    logic [1:0]  xfer_done = '0;
    logic [1:0]  term_pulse;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_xfer_count u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_size16(bus_size16), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .xfer_busy(xfer_busy), .xfer_done(xfer_done), .term_pulse(term_pulse)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  addr;
        logic        sz16;
        logic [15:0] wdata;
        logic [1:0]  busy;
        logic [1:0]  done;
        logic        chk_ch;
        logic [9:0]  exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd0, 1'b1, 16'hFC05, 2'b00, 2'b00, 1'b0, 10'h005}, // R2 upper bits dropped
        '{1'b1, 2'd0, 1'b0, 16'h12AA, 2'b00, 2'b00, 1'b0, 10'h0AA}, // R3 low byte
        '{1'b1, 2'd1, 1'b0, 16'h00FF, 2'b00, 2'b00, 1'b0, 10'h3AA}, // R4 high byte
        '{1'b1, 2'd2, 1'b1, 16'h0003, 2'b00, 2'b00, 1'b1, 10'h003}, // R2 ch1 word
        '{1'b0, 2'd0, 1'b0, 16'h0000, 2'b10, 2'b10, 1'b1, 10'h002}, // R6 decrement
        '{1'b1, 2'd2, 1'b1, 16'h0100, 2'b10, 2'b00, 1'b1, 10'h002}, // R5 write while busy
        '{1'b0, 2'd0, 1'b0, 16'h0000, 2'b10, 2'b10, 1'b1, 10'h001}, // R6
        '{1'b0, 2'd0, 1'b0, 16'h0000, 2'b10, 2'b10, 1'b1, 10'h000}, // R6 run ends
        '{1'b0, 2'd0, 1'b0, 16'h0000, 2'b00, 2'b01, 1'b0, 10'h3AA}, // R6 done while idle
        '{1'b1, 2'd0, 1'b1, 16'h0000, 2'b00, 2'b00, 1'b0, 10'h000}, // R7 load zero
        '{1'b0, 2'd0, 1'b0, 16'h0000, 2'b01, 2'b01, 1'b0, 10'h3FF}  // R7 wrap
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_chk(input string req, input logic [1:0] a, input logic sz,
                            input logic [15:0] exp);
        bus_wr = 1'b0; bus_addr = a; bus_size16 = sz;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic bus_cycle(input logic wr, input logic [1:0] a, input logic sz,
                             input logic [15:0] d, input logic [1:0] busy,
                             input logic [1:0] done);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_size16 = sz; bus_wdata = d;
        xfer_busy = busy; xfer_done = done;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; xfer_done = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        read_chk("R1 ch0", 2'd0, 1'b1, 16'h0000);
        read_chk("R1 ch1", 2'd2, 1'b1, 16'h0000);
        check("R1 term", {14'b0, term_pulse}, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            bus_cycle(VEC[i].wr, VEC[i].addr, VEC[i].sz16, VEC[i].wdata,
                      VEC[i].busy, VEC[i].done);
            read_chk($sformatf("vector %0d", i), {VEC[i].chk_ch, 1'b0}, 1'b1,
                     {6'b0, VEC[i].exp});
        end

        // R9: byte reads mid-run, ch0 = 3FF and still busy
        read_chk("R9 low byte", 2'd0, 1'b0, 16'h00FF);
        read_chk("R9 high byte", 2'd1, 1'b0, 16'h0003);

        // R10: ch0 decrements, ch1 idle with a done strobe stays put
        bus_cycle(1'b0, 2'd0, 1'b1, 16'h0, 2'b01, 2'b11);
        read_chk("R10 ch0", 2'd0, 1'b1, 16'h03FE);
        read_chk("R10 ch1", 2'd2, 1'b1, 16'h0000);

        // release busy, let state return to idle
        bus_cycle(1'b0, 2'd0, 1'b1, 16'h0, 2'b00, 2'b00);
        bus_cycle(1'b0, 2'd0, 1'b1, 16'h0, 2'b00, 2'b00);

        // R6: write and done together on idle ch1, write wins
        bus_cycle(1'b1, 2'd2, 1'b1, 16'h0055, 2'b00, 2'b10);
        read_chk("R6 write priority", 2'd2, 1'b1, 16'h0055);

        // R8: terminal pulse on 1 -> 0
        bus_cycle(1'b1, 2'd2, 1'b1, 16'h0001, 2'b00, 2'b00);
        check("R8 no early term", {14'b0, term_pulse}, 16'h0000);
        bus_cycle(1'b0, 2'd2, 1'b1, 16'h0, 2'b10, 2'b10);
        check("R8 term high", {14'b0, term_pulse}, 16'h0002);
        read_chk("R8 count zero", 2'd2, 1'b1, 16'h0000);
        bus_cycle(1'b0, 2'd2, 1'b1, 16'h0, 2'b10, 2'b00);
        check("R8 term one cycle", {14'b0, term_pulse}, 16'h0000);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule